// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a combinational datapath slice that turns two operand words, a four-bit select and a carry input into one result word and a carry output. Addition, subtraction, increment, decrement and plain transfer all come from a single ripple-carry adder. Its second input is steered per bit to the B operand, its complement, all zeros or all ones, and the carry input is added on top.

A bitwise logic stage and a one-position shifter run beside the adder, and a final selector picks one of the three results. The select bits and the carry input together form one five-bit operation code. A surrounding datapath places the result in its registers. This block holds no state of its own.

The shifter takes its vacated end bit from one of two serial fill inputs. One is used for right shifts and one for left shifts.

Top module: `alsu_unit`

## Requirements
- R1: The mode is sel[3:2]: 00 arithmetic, 01 logic, 10 shift right, 11 shift left.
- R2: In arithmetic mode, the adder's second operand Y is picked by sel[1:0]: 00 gives B, 01 gives ~B, 10 gives all zeros, 11 gives all ones. {cout, f} equals A + Y + cin computed at WIDTH+1 bits.
- R3: Code sel=0001 with cin=1 gives A-B, with cout=1 exactly when A >= B unsigned. With cin=0 it gives A-B-1.
- R4: Code sel=0010 gives A (cin=0) or A+1 (cin=1). Code sel=0011 gives A-1 with cout=0 when A=0 and cin=0. With cin=1 it gives A with cout=1.
- R5: In logic mode, sel[1:0] = 00, 01, 10, 11 give A AND B, A OR B, A XOR B, NOT A.
- R6: In logic mode, cin has no effect on f.
- R7: In shift-right mode, f[i] = A[i+1] for i < WIDTH-1, and f[WIDTH-1] = fill_msb.
- R8: In shift-left mode, f[i] = A[i-1] for i > 0, and f[0] = fill_lsb.
- R9: In both shift modes, sel[1:0], cin, B and the unused fill input have no effect on f.
- R10: cout is 0 in logic and shift modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand; the only operand of shifts and NOT |
| b | input | WIDTH | Second operand |
| sel | input | 4 | Mode in [3:2], sub-operation in [1:0] |
| cin | input | 1 | Carry into the adder |
| fill_msb | input | 1 | Bit that enters the top position on a right shift |
| fill_lsb | input | 1 | Bit that enters the bottom position on a left shift |
| f | output | WIDTH | Selected result |
| cout | output | 1 | Adder carry out; 0 outside arithmetic mode |

## Verification
The assertions check on every evaluation that the ripple chain agrees with a wide sum of A, the steered operand and cin. They also check that each shift places its fill bit at the vacated end and passes the neighbour bits through the final selector, and that the logic path delivers A AND B. Only the bench's scenarios can show that the operation codes map to the intended operations. The same goes for subtraction borrow and decrement wrap-around at zero, and for the requirements that cin, the spare select bits and the unused fill input have no effect. These come from comparing the ports against a reference model computed independently.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    MODE_ARITH = 2'b00,
    MODE_LOGIC = 2'b01,
    MODE_SHR   = 2'b10,
    MODE_SHL   = 2'b11
  } alsu_mode_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NOTB = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } alsu_ysel_e;

  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } alsu_lop_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       ysel,
  input  logic             cin,
  output logic [WIDTH-1:0] d,
  output logic             cout
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] y;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (alsu_ysel_e'(ysel))
        YSEL_B:    y[i] = b[i];
        YSEL_NOTB: y[i] = ~b[i];
        YSEL_ZERO: y[i] = 1'b0;
        default:   y[i] = 1'b1;
      endcase
    end
    assign d[i]       = a[i] ^ y[i] ^ carry[i];
    assign carry[i+1] = (a[i] & y[i]) | (carry[i] & (a[i] ^ y[i]));
  end

  assign cout = carry[WIDTH];

  // R2: ripple chain agrees with a wide sum
  always_comb begin
    a_r2_chain_sum : assert ({cout, d} ==
      ({1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
      else $error("ripple chain disagrees with wide sum");
  end
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       op,
  output logic [WIDTH-1:0] e
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (alsu_lop_e'(op))
        LOP_AND: e[i] = a[i] & b[i];
        LOP_OR:  e[i] = a[i] | b[i];
        LOP_XOR: e[i] = a[i] ^ b[i];
        default: e[i] = ~a[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic             fill_msb,
  input  logic             fill_lsb,
  output logic [WIDTH-1:0] shr,
  output logic [WIDTH-1:0] shl
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH-1) begin : g_top
      assign shr[i] = fill_msb;
    end else begin : g_mid_r
      assign shr[i] = a[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl[i] = fill_lsb;
    end else begin : g_mid_l
      assign shl[i] = a[i-1];
    end
  end
endmodule

// File: rtl/alsu_unit.sv
module alsu_unit
  import alsu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [3:0]       sel,
  input  logic             cin,
  input  logic             fill_msb,
  input  logic             fill_lsb,
  output logic [WIDTH-1:0] f,
  output logic             cout
);
  alsu_mode_e       mode;
  logic [WIDTH-1:0] arith_d, logic_e, shr_h, shl_h;
  logic             arith_c;

  assign mode = alsu_mode_e'(sel[3:2]);

  alsu_arith #(.WIDTH(WIDTH)) u_arith (
    .a(a), .b(b), .ysel(sel[1:0]), .cin(cin), .d(arith_d), .cout(arith_c)
  );

  alsu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(a), .b(b), .op(sel[1:0]), .e(logic_e)
  );

  alsu_shift #(.WIDTH(WIDTH)) u_shift (
    .a(a), .fill_msb(fill_msb), .fill_lsb(fill_lsb), .shr(shr_h), .shl(shl_h)
  );

  always_comb begin
    unique case (mode)
      MODE_ARITH: f = arith_d;
      MODE_LOGIC: f = logic_e;
      MODE_SHR:   f = shr_h;
      default:    f = shl_h;
    endcase
  end

  assign cout = (mode == MODE_ARITH) & arith_c;

  always_comb begin
    // R7: right shift moves neighbours down and fills the top
    if (mode == MODE_SHR) begin
      a_r7_shr_body : assert (f[WIDTH-2:0] == a[WIDTH-1:1] && f[WIDTH-1] == fill_msb)
        else $error("right shift result wrong");
    end
    // R8: left shift moves neighbours up and fills the bottom
    if (mode == MODE_SHL) begin
      a_r8_shl_body : assert (f[WIDTH-1:1] == a[WIDTH-2:0] && f[0] == fill_lsb)
        else $error("left shift result wrong");
    end
    // R5: logic AND reaches the output
    if (mode == MODE_LOGIC && sel[1:0] == 2'b00) begin
      a_r5_and_path : assert (f == (a & b))
        else $error("logic AND path wrong");
    end
  end
endmodule

// File: tb/sim_alsu_unit.sv
module sim_alsu_unit;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [W-1:0] a, b, f;
  logic [3:0] sel;
  logic cin, fmsb, flsb, cout;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alsu_unit #(.WIDTH(W)) u0 (
    .a(a), .b(b), .sel(sel), .cin(cin), .fill_msb(fmsb), .fill_lsb(flsb),
    .f(f), .cout(cout)
  );

  function automatic logic [W:0] model(input logic [W-1:0] ma, input logic [W-1:0] mb,
                                       input logic [3:0] ms, input logic mc,
                                       input logic fm, input logic fl);
    logic [W-1:0] y;
    case (ms[3:2])
      2'b00: begin
        case (ms[1:0])
          2'b00: y = mb;
          2'b01: y = ~mb;
          2'b10: y = '0;
          default: y = '1;
        endcase
        return {1'b0, ma} + {1'b0, y} + (W+1)'(mc);
      end
      2'b01: begin
        case (ms[1:0])
          2'b00: return {1'b0, ma & mb};
          2'b01: return {1'b0, ma | mb};
          2'b10: return {1'b0, ma ^ mb};
          default: return {1'b0, ~ma};
        endcase
      end
      2'b10: return {1'b0, fm, ma[W-1:1]};
      default: return {1'b0, ma[W-2:0], fl};
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic [3:0] ts,
                       input logic tc, input logic tm, input logic tl);
    a = ta; b = tb_; sel = ts; cin = tc; fmsb = tm; flsb = tl;
    #1;
  endtask

  task automatic check(input string req, input logic [W:0] exp);
    n_cmp++;
    if ({cout, f} !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h sel=%b cin=%b got {cout,f}=%h expected %h",
               req, a, b, sel, cin, {cout, f}, exp);
    end
  endtask

  task automatic t_zero_inputs;
    drive('0, '0, 4'b0000, 1'b0, 1'b0, 1'b0);
    check("R1", '0);
  endtask

  task automatic t_arith_sweep;   // R1 R2 R10
    for (int ia = 0; ia < 256; ia += 17)
      for (int ib = 0; ib < 256; ib += 23)
        for (int s = 0; s < 16; s++)
          for (int c = 0; c < 2; c++) begin
            drive(W'(ia), W'(ib), 4'(s), 1'(c), 1'(s), 1'(c));
            check(s < 4 ? "R2" : "R10", model(W'(ia), W'(ib), 4'(s), 1'(c), 1'(s), 1'(c)));
          end
  endtask

  task automatic t_subtract;      // R3
    drive(8'd50, 8'd20, 4'b0001, 1'b1, 1'b0, 1'b0); check("R3", {1'b1, 8'd30});
    drive(8'd20, 8'd50, 4'b0001, 1'b1, 1'b0, 1'b0); check("R3", {1'b0, 8'd226});
    drive(8'd77, 8'd77, 4'b0001, 1'b1, 1'b0, 1'b0); check("R3", {1'b1, 8'd0});
    drive(8'd50, 8'd20, 4'b0001, 1'b0, 1'b0, 1'b0); check("R3", {1'b1, 8'd29});
  endtask

  task automatic t_inc_dec;       // R4
    drive(8'h5A, 8'hFF, 4'b0010, 1'b0, 1'b0, 1'b0); check("R4", {1'b0, 8'h5A});
    drive(8'hFF, 8'h00, 4'b0010, 1'b1, 1'b0, 1'b0); check("R4", {1'b1, 8'h00});
    drive(8'h00, 8'h33, 4'b0011, 1'b0, 1'b0, 1'b0); check("R4", {1'b0, 8'hFF});
    drive(8'h80, 8'h33, 4'b0011, 1'b0, 1'b0, 1'b0); check("R4", {1'b1, 8'h7F});
    drive(8'hC3, 8'h00, 4'b0011, 1'b1, 1'b0, 1'b0); check("R4", {1'b1, 8'hC3});
  endtask

  task automatic t_logic;         // R5 R6 R10
    drive(8'hCC, 8'hAA, 4'b0100, 1'b0, 1'b0, 1'b0); check("R5", {1'b0, 8'h88});
    drive(8'hCC, 8'hAA, 4'b0101, 1'b0, 1'b0, 1'b0); check("R5", {1'b0, 8'hEE});
    drive(8'hCC, 8'hAA, 4'b0110, 1'b0, 1'b0, 1'b0); check("R5", {1'b0, 8'h66});
    drive(8'hCC, 8'hAA, 4'b0111, 1'b0, 1'b0, 1'b0); check("R5", {1'b0, 8'h33});
    drive(8'hFF, 8'hFF, 4'b0100, 1'b1, 1'b0, 1'b0); check("R6", {1'b0, 8'hFF});
    drive(8'hCC, 8'hAA, 4'b0110, 1'b1, 1'b0, 1'b0); check("R6", {1'b0, 8'h66});
  endtask

  task automatic t_shift;         // R7 R8 R9 R10
    drive(8'b1001_0110, 8'hFF, 4'b1000, 1'b0, 1'b1, 1'b0); check("R7", {1'b0, 8'b1100_1011});
    drive(8'b1001_0111, 8'h00, 4'b1000, 1'b0, 1'b0, 1'b1); check("R7", {1'b0, 8'b0100_1011});
    drive(8'b1001_0110, 8'hFF, 4'b1100, 1'b0, 1'b0, 1'b1); check("R8", {1'b0, 8'b0010_1101});
    drive(8'b1001_0110, 8'h00, 4'b1100, 1'b0, 1'b1, 1'b0); check("R8", {1'b0, 8'b0010_1100});
    drive(8'b1001_0110, 8'h5A, 4'b1011, 1'b1, 1'b1, 1'b1); check("R9", {1'b0, 8'b1100_1011});
    drive(8'b1001_0110, 8'hA5, 4'b1111, 1'b1, 1'b0, 1'b0); check("R9", {1'b0, 8'b0010_1100});
  endtask

  initial begin
    a = '0; b = '0; sel = '0; cin = 1'b0; fmsb = 1'b0; flsb = 1'b0;
    @(negedge clk);
    t_zero_inputs();
    t_arith_sweep();
    t_subtract();
    t_inc_dec();
    t_logic();
    t_shift();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule